// File: doc/BRIEF.md
# Batched Request Switch with Tag-Steered Return Path

This block joins several requester ports onto one downstream channel. In any cycle where the batch queue has room, the valid requests of all ports are taken in together as one batch. Each request carries a tag and a data word. Batches wait in arrival order. The switch hands one request of the oldest batch to the downstream channel per cycle, through a pipeline of fixed length. It moves on to the next batch only after every request of the current batch has gone.

A mode input picks the arbitration. In fixed mode the lowest-numbered pending port wins. In rotating mode the search starts one place after the port that won last, wrapping past the highest port. Each forwarded request stores its source port in a table indexed by its tag. A response from downstream is steered back to that port one cycle later, and this uses up the table entry. A response whose tag has no entry produces an error pulse and reaches no port.

Top module: `tag_switch`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `dn_valid`, `rsp_out_valid` and `rsp_err` are 0 and `req_ready` is 1.
- R2: On a clock edge where `req_ready` is 1 and any `req_valid` bit is set, all set bits are stored together as one batch. The tag of port p is `req_tag[p*TAG_W +: TAG_W]` and its data is `req_data[p*DATA_W +: DATA_W]`. Once `BATCH_DEPTH` batches are held, `req_ready` is 0 and requests presented on that edge are not stored.
- R3: In every cycle where a stored batch exists, exactly one request is granted, always from the oldest batch. A batch is removed once its last request is granted, so no request of a later batch is granted before it.
- R4: When `rr_mode` is 0, the grant goes to the lowest port index still pending in the oldest batch.
- R5: When `rr_mode` is 1, the search begins at the index one above the previous grant, wrapping to 0 after `N_PORTS-1`, and goes upward modulo `N_PORTS`. After a cycle spent with `rr_mode` at 0, the search begins at index 0.
- R6: A request stored on edge k and granted in the cycle after edge k+g appears on `dn_valid`/`dn_tag`/`dn_data` for one cycle, `FWD_LAT` edges after its grant edge, with its tag and data unchanged.
- R7: A response offered on `rsp_in_valid` with a tag whose entry is held gives, in the next cycle, `rsp_out_valid` with only the bit of the port that last forwarded that tag set, and `rsp_out_tag`/`rsp_out_data` equal to the response. The entry is then removed.
- R8: A response whose tag has no held entry gives `rsp_err` high and `rsp_out_valid` all zero in the next cycle. A second response to the same tag without a new forward in between is such a case.
- R9: When a response and a grant carry the same tag on one edge, the response is steered by the entry held before that edge, and the entry left afterwards names the newly granted port.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rr_mode | input | 1 | 1 selects rotating arbitration, 0 selects fixed priority |
| req_valid | input | N_PORTS | Per-port request valid |
| req_tag | input | N_PORTS*TAG_W | Per-port request tags, port p in slice p |
| req_data | input | N_PORTS*DATA_W | Per-port request data, port p in slice p |
| req_ready | output | 1 | Batch queue can take a batch on this edge |
| dn_valid | output | 1 | Forwarded request valid |
| dn_tag | output | TAG_W | Forwarded request tag |
| dn_data | output | DATA_W | Forwarded request data |
| rsp_in_valid | input | 1 | Response from downstream valid |
| rsp_in_tag | input | TAG_W | Response tag |
| rsp_in_data | input | DATA_W | Response data |
| rsp_out_valid | output | N_PORTS | One-hot destination of the returned response |
| rsp_out_tag | output | TAG_W | Returned response tag |
| rsp_out_data | output | DATA_W | Returned response data |
| rsp_err | output | 1 | Response tag had no held entry |

## Verification
The bench first sends a full batch in fixed mode, then a high-ports batch followed at once by a low-ports batch. The second case shows whether batch order is kept or ports are simply served by index. It repeats full and sparse batches in rotating mode, where the output order shows the cursor moving and wrapping, and it holds requests for many cycles in a row so the queue fills and refuses batches. Responses are sent for forwarded tags, for tags never used, and twice for the same tag, which separates correct routing from stale table entries. A directed case puts a response and a grant of the same tag on one edge. A long random mix with mode changes finishes the run.

// File: rtl/tag_switch_pkg.sv
package tag_switch_pkg;
  typedef enum logic {
    ARB_FIXED  = 1'b0,
    ARB_ROTATE = 1'b1
  } arb_mode_e;
endpackage

// File: rtl/batch_queue.sv
// Queue of request batches; the head's pending mask is edited in place.
module batch_queue #(
  parameter int N      = 4,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4,
  parameter int IDX_W  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  push,
  input  logic [N-1:0]          push_mask,
  input  logic [N*TAG_W-1:0]    push_tag,
  input  logic [N*DATA_W-1:0]   push_data,
  input  logic                  take,
  input  logic [IDX_W-1:0]      take_idx,
  output logic [N-1:0]          head_mask,
  output logic [N*TAG_W-1:0]    head_tag,
  output logic [N*DATA_W-1:0]   head_data,
  output logic                  full,
  output logic                  empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [N-1:0]        mask_q [DEPTH];
  logic [N*TAG_W-1:0]  tag_q  [DEPTH];
  logic [N*DATA_W-1:0] data_q [DEPTH];
  logic [PTR_W-1:0]    wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic [N-1:0]        rest_mask;
  logic                do_push, retire;

  assign full      = (cnt_q == CNT_W'(DEPTH));
  assign empty     = (cnt_q == '0);
  assign head_mask = empty ? '0 : mask_q[rd_q];
  assign head_tag  = tag_q[rd_q];
  assign head_data = data_q[rd_q];
  assign rest_mask = head_mask & ~(N'(1) << take_idx);
  assign do_push   = push & ~full;
  assign retire    = take & ~empty & (rest_mask == '0);

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (do_push) wr_d = (wr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
    if (retire)  rd_d = (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
    if (do_push && !retire)      cnt_d = cnt_q + 1'b1;
    else if (!do_push && retire) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      for (int e = 0; e < DEPTH; e++) mask_q[e] <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
      if (take && !empty) mask_q[rd_q] <= rest_mask;
      if (do_push)        mask_q[wr_q] <= push_mask;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) begin
      tag_q[wr_q]  <= push_tag;
      data_q[wr_q] <= push_data;
    end
  end
endmodule

// File: rtl/grant_pick.sv
// Finds the first set mask bit at or after start, wrapping modulo N.
module grant_pick #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0]     mask,
  input  logic [IDX_W-1:0] start,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      int j;
      j = int'(start) + i;
      if (j >= N) j = j - N;
      if (mask[j]) begin
        found = 1'b1;
        idx   = IDX_W'(j);
      end
    end
  end
endmodule

// File: rtl/tag_map.sv
// Direct-indexed table: tag -> source port, with a held flag per tag.
module tag_map #(
  parameter int TAG_W = 4,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [TAG_W-1:0] set_tag,
  input  logic [IDX_W-1:0] set_port,
  input  logic             clr_en,
  input  logic [TAG_W-1:0] clr_tag,
  input  logic [TAG_W-1:0] look_tag,
  output logic             look_hit,
  output logic [IDX_W-1:0] look_port
);
  localparam int ENTRIES = 1 << TAG_W;

  logic [ENTRIES-1:0] held_q, held_d;
  logic [IDX_W-1:0]   port_q [ENTRIES];

  assign look_hit  = held_q[look_tag];
  assign look_port = port_q[look_tag];

  // a new record on the same tag overrides the removal
  always_comb begin
    held_d = held_q;
    if (clr_en) held_d[clr_tag] = 1'b0;
    if (set_en) held_d[set_tag] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= '0;
    else        held_q <= held_d;
  end

  always_ff @(posedge clk) begin
    if (set_en) port_q[set_tag] <= set_port;
  end
endmodule

// File: rtl/tag_switch.sv
module tag_switch
  import tag_switch_pkg::*;
#(
  parameter int N_PORTS     = 4,
  parameter int TAG_W       = 4,
  parameter int DATA_W      = 8,
  parameter int BATCH_DEPTH = 4,
  parameter int FWD_LAT     = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      rr_mode,
  input  logic [N_PORTS-1:0]        req_valid,
  input  logic [N_PORTS*TAG_W-1:0]  req_tag,
  input  logic [N_PORTS*DATA_W-1:0] req_data,
  output logic                      req_ready,
  output logic                      dn_valid,
  output logic [TAG_W-1:0]          dn_tag,
  output logic [DATA_W-1:0]         dn_data,
  input  logic                      rsp_in_valid,
  input  logic [TAG_W-1:0]          rsp_in_tag,
  input  logic [DATA_W-1:0]         rsp_in_data,
  output logic [N_PORTS-1:0]        rsp_out_valid,
  output logic [TAG_W-1:0]          rsp_out_tag,
  output logic [DATA_W-1:0]         rsp_out_data,
  output logic                      rsp_err
);
  localparam int IDX_W = (N_PORTS > 1) ? $clog2(N_PORTS) : 1;

  arb_mode_e                 mode;
  logic                      bq_full, bq_empty, bq_push;
  logic [N_PORTS-1:0]        head_mask;
  logic [N_PORTS*TAG_W-1:0]  head_tag;
  logic [N_PORTS*DATA_W-1:0] head_data;
  logic [IDX_W-1:0]          cursor_q, cursor_d, start_idx, grant_idx;
  logic                      pick_found, grant_v;
  logic [TAG_W-1:0]          grant_tag;
  logic [DATA_W-1:0]         grant_data;

  assign mode      = rr_mode ? ARB_ROTATE : ARB_FIXED;
  assign req_ready = ~bq_full;
  assign bq_push   = (|req_valid) & ~bq_full;

  batch_queue #(
    .N(N_PORTS), .TAG_W(TAG_W), .DATA_W(DATA_W),
    .DEPTH(BATCH_DEPTH), .IDX_W(IDX_W)
  ) u_queue (
    .clk(clk), .rst_n(rst_n),
    .push(bq_push), .push_mask(req_valid), .push_tag(req_tag), .push_data(req_data),
    .take(grant_v), .take_idx(grant_idx),
    .head_mask(head_mask), .head_tag(head_tag), .head_data(head_data),
    .full(bq_full), .empty(bq_empty)
  );

  assign start_idx = (mode == ARB_ROTATE) ? cursor_q : '0;

  grant_pick #(.N(N_PORTS), .IDX_W(IDX_W)) u_pick (
    .mask(head_mask), .start(start_idx), .found(pick_found), .idx(grant_idx)
  );

  assign grant_v    = pick_found & ~bq_empty;
  assign grant_tag  = head_tag[grant_idx*TAG_W +: TAG_W];
  assign grant_data = head_data[grant_idx*DATA_W +: DATA_W];

  always_comb begin
    cursor_d = cursor_q;
    if (mode == ARB_FIXED) cursor_d = '0;
    else if (grant_v)
      cursor_d = (grant_idx == IDX_W'(N_PORTS - 1)) ? '0 : grant_idx + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cursor_q <= '0;
    else        cursor_q <= cursor_d;
  end

  // fixed-length forward pipeline
  logic [FWD_LAT-1:0] st_v;
  logic [TAG_W-1:0]   st_tag  [FWD_LAT];
  logic [DATA_W-1:0]  st_data [FWD_LAT];

  for (genvar s = 0; s < FWD_LAT; s++) begin : g_stage
    logic              in_v;
    logic [TAG_W-1:0]  in_tag;
    logic [DATA_W-1:0] in_data;
    if (s == 0) begin : g_head
      assign in_v    = grant_v;
      assign in_tag  = grant_tag;
      assign in_data = grant_data;
    end else begin : g_tail
      assign in_v    = st_v[s-1];
      assign in_tag  = st_tag[s-1];
      assign in_data = st_data[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_v[s] <= 1'b0;
      else        st_v[s] <= in_v;
    end
    always_ff @(posedge clk) begin
      if (in_v) begin
        st_tag[s]  <= in_tag;
        st_data[s] <= in_data;
      end
    end
  end

  assign dn_valid = st_v[FWD_LAT-1];
  assign dn_tag   = st_tag[FWD_LAT-1];
  assign dn_data  = st_data[FWD_LAT-1];

  // response return path
  logic               map_hit;
  logic [IDX_W-1:0]   map_port;
  logic [N_PORTS-1:0] rov_d;
  logic               err_d;

  tag_map #(.TAG_W(TAG_W), .IDX_W(IDX_W)) u_map (
    .clk(clk), .rst_n(rst_n),
    .set_en(grant_v), .set_tag(grant_tag), .set_port(grant_idx),
    .clr_en(rsp_in_valid & map_hit), .clr_tag(rsp_in_tag),
    .look_tag(rsp_in_tag), .look_hit(map_hit), .look_port(map_port)
  );

  always_comb begin
    rov_d = '0;
    if (rsp_in_valid && map_hit) rov_d = N_PORTS'(1) << map_port;
    err_d = rsp_in_valid & ~map_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_out_valid <= '0;
      rsp_err       <= 1'b0;
    end else begin
      rsp_out_valid <= rov_d;
      rsp_err       <= err_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rsp_in_valid) begin
      rsp_out_tag  <= rsp_in_tag;
      rsp_out_data <= rsp_in_data;
    end
  end
endmodule

// File: rtl/tag_switch_chk.sv
module tag_switch_chk #(
  parameter int N_PORTS = 4,
  parameter int IDX_W   = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               rr_mode,
  input logic [N_PORTS-1:0] req_valid,
  input logic               req_ready,
  input logic               rsp_in_valid,
  input logic [N_PORTS-1:0] rsp_out_valid,
  input logic               rsp_err,
  input logic               bq_empty,
  input logic               grant_v,
  input logic [IDX_W-1:0]   grant_idx,
  input logic [N_PORTS-1:0] head_mask,
  input logic [IDX_W-1:0]   cursor_q
);
  // R2
  stored_batch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && (|req_valid)) |=> !bq_empty);

  // R3
  grant_when_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bq_empty |-> grant_v);

  // R4
  lowest_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rr_mode && grant_v) |-> ((head_mask & ((N_PORTS'(1) << grant_idx) - 1'b1)) == '0));

  // R5
  cursor_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rr_mode && grant_v) |=>
      (cursor_q == ((int'($past(grant_idx)) == N_PORTS - 1) ? IDX_W'(0)
                                                            : IDX_W'($past(grant_idx) + 1'b1))));

  // R7
  routed_only_after_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_out_valid != '0) |-> ($past(rsp_in_valid) && $onehot0(rsp_out_valid)));

  // R8
  err_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> ($past(rsp_in_valid) && (rsp_out_valid == '0)));
endmodule

bind tag_switch tag_switch_chk #(.N_PORTS(N_PORTS), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rr_mode(rr_mode), .req_valid(req_valid),
  .req_ready(req_ready), .rsp_in_valid(rsp_in_valid), .rsp_out_valid(rsp_out_valid),
  .rsp_err(rsp_err), .bq_empty(bq_empty), .grant_v(grant_v), .grant_idx(grant_idx),
  .head_mask(head_mask), .cursor_q(cursor_q)
);

// File: tb/sim_tag_switch.sv
`timescale 1ns/1ps
module sim_tag_switch;
  localparam int N  = 4;
  localparam int TW = 4;
  localparam int DW = 8;
  localparam int BD = 4;
  localparam int FL = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rr_mode = 1'b0;
  logic [N-1:0] req_valid = '0;
  logic [N*TW-1:0] req_tag = '0;
  logic [N*DW-1:0] req_data = '0;
  logic req_ready, dn_valid, rsp_err;
  logic [TW-1:0] dn_tag, rsp_out_tag;
  logic [DW-1:0] dn_data, rsp_out_data;
  logic rsp_in_valid = 1'b0;
  logic [TW-1:0] rsp_in_tag = '0;
  logic [DW-1:0] rsp_in_data = '0;
  logic [N-1:0] rsp_out_valid;

  always #2.5 clk = ~clk;

  tag_switch #(.N_PORTS(N), .TAG_W(TW), .DATA_W(DW), .BATCH_DEPTH(BD), .FWD_LAT(FL)) u0 (
    .clk(clk), .rst_n(rst_n), .rr_mode(rr_mode),
    .req_valid(req_valid), .req_tag(req_tag), .req_data(req_data), .req_ready(req_ready),
    .dn_valid(dn_valid), .dn_tag(dn_tag), .dn_data(dn_data),
    .rsp_in_valid(rsp_in_valid), .rsp_in_tag(rsp_in_tag), .rsp_in_data(rsp_in_data),
    .rsp_out_valid(rsp_out_valid), .rsp_out_tag(rsp_out_tag), .rsp_out_data(rsp_out_data),
    .rsp_err(rsp_err)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference ----------------
  typedef struct packed {
    logic [N-1:0]    m;
    logic [N*TW-1:0] t;
    logic [N*DW-1:0] d;
  } batch_t;

  batch_t      bq[$];
  int          cur;
  bit          m_pv [FL];
  logic [TW-1:0] m_pt [FL];
  logic [DW-1:0] m_pd [FL];
  bit          tab_v [1 << TW];
  int          tab_p [1 << TW];
  logic [N-1:0]  m_rov;
  logic [TW-1:0] m_rot;
  logic [DW-1:0] m_rod;
  bit            m_err;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bq.delete();
      cur = 0;
      for (int k = 0; k < FL; k++) m_pv[k] = 1'b0;
      for (int t = 0; t < (1 << TW); t++) tab_v[t] = 1'b0;
      m_rov = '0;
      m_err = 1'b0;
    end else begin : step
      int bsz, st, gi;
      bit g;
      logic [TW-1:0] gt;
      logic [DW-1:0] gd;
      batch_t hb;
      bsz = bq.size();
      g = 1'b0; gi = 0; gt = '0; gd = '0;
      if (bsz > 0) begin
        hb = bq[0];
        st = rr_mode ? cur : 0;
        for (int i = 0; i < N; i++) begin
          int j;
          j = (st + i) % N;
          if (!g && hb.m[j]) begin g = 1'b1; gi = j; end
        end
        gt = hb.t[gi*TW +: TW];
        gd = hb.d[gi*DW +: DW];
        hb.m[gi] = 1'b0;
        if (hb.m == '0) void'(bq.pop_front());
        else bq[0] = hb;
      end
      cur = rr_mode ? (g ? (gi + 1) % N : cur) : 0;
      for (int k = FL - 1; k > 0; k--) begin
        m_pv[k] = m_pv[k-1]; m_pt[k] = m_pt[k-1]; m_pd[k] = m_pd[k-1];
      end
      m_pv[0] = g; m_pt[0] = gt; m_pd[0] = gd;
      if (rsp_in_valid) begin
        m_rot = rsp_in_tag;
        m_rod = rsp_in_data;
        if (tab_v[rsp_in_tag]) begin
          m_rov = N'(1) << tab_p[rsp_in_tag];
          m_err = 1'b0;
          tab_v[rsp_in_tag] = 1'b0;
        end else begin
          m_rov = '0;
          m_err = 1'b1;
        end
      end else begin
        m_rov = '0;
        m_err = 1'b0;
      end
      if (g) begin tab_v[gt] = 1'b1; tab_p[gt] = gi; end
      if ((|req_valid) && bsz < BD) bq.push_back('{m: req_valid, t: req_tag, d: req_data});
    end
  end

  // compare every cycle, 1 ns after the edge
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      check(req_ready == (bq.size() < BD), "R2", "req_ready", req_ready, bq.size() < BD);
      check(dn_valid == m_pv[FL-1], "R3/R6", "dn_valid", dn_valid, m_pv[FL-1]);
      if (m_pv[FL-1]) begin
        check(dn_tag == m_pt[FL-1], "R4/R5", "dn_tag", dn_tag, m_pt[FL-1]);
        check(dn_data == m_pd[FL-1], "R6", "dn_data", dn_data, m_pd[FL-1]);
      end
      check(rsp_out_valid == m_rov, "R7", "rsp_out_valid", rsp_out_valid, m_rov);
      check(rsp_err == m_err, "R8", "rsp_err", rsp_err, m_err);
      if (m_rov != '0 || m_err) begin
        check(rsp_out_tag == m_rot, "R7", "rsp_out_tag", rsp_out_tag, m_rot);
        check(rsp_out_data == m_rod, "R7", "rsp_out_data", rsp_out_data, m_rod);
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic drive(input logic [N-1:0] m, input logic [N*TW-1:0] t,
                       input logic [N*DW-1:0] d, input bit rv,
                       input logic [TW-1:0] rt, input logic [DW-1:0] rd);
    @(negedge clk);
    req_valid = m; req_tag = t; req_data = d;
    rsp_in_valid = rv; rsp_in_tag = rt; rsp_in_data = rd;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive('0, '0, '0, 1'b0, '0, '0);
  endtask

  task automatic rsp(input logic [TW-1:0] t, input logic [DW-1:0] d);
    drive('0, '0, '0, 1'b1, t, d);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: values under reset
    check(dn_valid == 1'b0, "R1", "dn_valid in reset", dn_valid, 0);
    check(rsp_out_valid == '0, "R1", "rsp_out_valid in reset", rsp_out_valid, 0);
    check(rsp_err == 1'b0, "R1", "rsp_err in reset", rsp_err, 0);
    check(req_ready == 1'b1, "R1", "req_ready in reset", req_ready, 1);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check(dn_valid == 1'b0 && rsp_out_valid == '0, "R1", "outputs after reset",
          {dn_valid, rsp_out_valid}, 0);

    // R4: full batch in fixed mode, tags 0..3
    rr_mode = 1'b0;
    drive(4'b1111, {4'd3, 4'd2, 4'd1, 4'd0}, {8'hA3, 8'hA2, 8'hA1, 8'hA0}, 0, 0, 0);
    idle(7);
    // R3: high ports batch then low ports batch; order of batches must hold
    drive(4'b1100, {4'd7, 4'd6, 4'd0, 4'd0}, {8'hB3, 8'hB2, 8'h00, 8'h00}, 0, 0, 0);
    drive(4'b0011, {4'd0, 4'd0, 4'd5, 4'd4}, {8'h00, 8'h00, 8'hB1, 8'hB0}, 0, 0, 0);
    idle(7);

    // R5: rotating mode, consecutive full and sparse batches
    rr_mode = 1'b1;
    drive(4'b1111, {4'd11, 4'd10, 4'd9, 4'd8}, {8'hC3, 8'hC2, 8'hC1, 8'hC0}, 0, 0, 0);
    drive(4'b0101, {4'd0, 4'd12, 4'd0, 4'd14}, {8'h00, 8'hC6, 8'h00, 8'hC4}, 0, 0, 0);
    drive(4'b1010, {4'd15, 4'd0, 4'd13, 4'd0}, {8'hC7, 8'h00, 8'hC5, 8'h00}, 0, 0, 0);
    idle(10);

    // R7: responses for held tags
    for (int t = 0; t < 16; t++) rsp(4'(t), 8'(8'h40 + t));
    // R8: every tag was consumed above, these must error
    rsp(4'd3, 8'h77);
    rsp(4'd9, 8'h78);
    idle(3);

    // R2: hold requests so the queue fills and refuses batches
    for (int c = 0; c < 12; c++)
      drive(4'b1111, {4'(c), 4'(c + 1), 4'(c + 2), 4'(c + 3)},
            {8'(c), 8'(c + 16), 8'(c + 32), 8'(c + 48)}, 0, 0, 0);
    idle(20);

    // R9: tag 13 held for port 0, then regranted to port 2 while its response arrives
    rr_mode = 1'b0;
    for (int t = 0; t < 16; t++) rsp(4'(t), 8'h00);
    idle(2);
    drive(4'b0001, {4'd0, 4'd0, 4'd0, 4'd13}, {8'h0, 8'h0, 8'h0, 8'h5A}, 0, 0, 0);
    idle(5);
    drive(4'b0100, {4'd0, 4'd13, 4'd0, 4'd0}, {8'h0, 8'h6B, 8'h0, 8'h0}, 0, 0, 0);
    rsp(4'd13, 8'hE1);            // same edge as the grant of port 2
    @(posedge clk); #1;
    check(rsp_out_valid == 4'b0001, "R9", "old entry used", rsp_out_valid, 4'b0001);
    rsp(4'd13, 8'hE2);
    @(posedge clk); #1;
    check(rsp_out_valid == 4'b0100, "R9", "new entry kept", rsp_out_valid, 4'b0100);
    idle(4);

    // random mix
    for (int c = 0; c < 600; c++) begin
      if (c % 60 == 0) rr_mode = $urandom_range(0, 1);
      drive(($urandom_range(0, 2) == 0) ? 4'($urandom) : 4'b0000,
            {4'($urandom), 4'($urandom), 4'($urandom), 4'($urandom)},
            {8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom)},
            ($urandom_range(0, 1) == 1), 4'($urandom), 8'($urandom));
    end
    idle(20);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL R3 watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule